// File: doc/BRIEF.md
# Exception Vector Fetch Unit

This block turns an accepted exception number into one word read from a vector table in memory and returns the handler start address read from the table. The table base is held in a relocatable base register. Its reset value comes from a configuration input. A privileged write can change only the bits chosen by a write-mask parameter. The low bits of the base are always zero, to match the table alignment. The parameter `NUM_IRQ` sets the alignment: the table holds 16 + `NUM_IRQ` words, and its size is rounded up to a power of two, with a minimum of 32 words.

After reset the unit reads two words before it accepts any exception. Word 0 is the initial stack pointer. Word 1 is the start address of the reset handler. For any later exception number `k`, the unit reads the word at byte address base + 4·k. Interrupt `n` uses number 16 + `n`. A handler word must have bit 0 set to show that it points at code. If bit 0 is clear, an error flag is raised together with the result.

The memory side has one request at a time. The request is a single-cycle strobe, and the reply is a valid strobe that may come after any number of wait cycles.

Top module: `vec_fetch_unit`

## Requirements
- R1: While reset is held and after it is released, `base_q` equals `cfg_base_rst` with its low `ALIGN_LSB` bits cleared. `ALIGN_LSB` is 2 + log2(table alignment in words), with a minimum alignment of 32 words. With `NUM_IRQ`=21 the table has 37 words and is aligned to 64 words, so `ALIGN_LSB`=8.
- R2: A write with `reg_wr_en` and `reg_wr_priv` both high changes exactly the bits set in `WR_MASK` above bit `ALIGN_LSB`-1 to the written data. The change is visible on `base_q` one cycle later. Every other bit keeps its value. The default `WR_MASK` is 0x0FFF_FFFF.
- R3: A write with `reg_wr_priv` low leaves `base_q` unchanged.
- R4: After reset the unit issues a read at `base_q`, then a read at `base_q`+4. The first reply appears on `boot_sp`. The second reply appears on `boot_pc` and on `vec_handler`. `boot_done` and `exc_ready` stay low until the cycle after the second reply.
- R5: When `exc_req` is high while `exc_ready` is high, `exc_num` is accepted. The unit then issues exactly one read at `base_q` + 4·`exc_num`. Interrupt n therefore reads word 16+n. The cycle after the reply, `vec_valid` pulses for one cycle with `vec_handler` equal to the reply data.
- R6: `vec_err` is high exactly in the `vec_valid` cycles whose handler word has bit 0 equal to 0.
- R7: At most one read is outstanding. `mem_req` is a one-cycle strobe that is not raised again before `mem_rvalid` returns. `exc_ready` is low while a read is in progress, and `exc_req` is ignored while `exc_ready` is low.
- R8: Results are correct for any reply latency, including a reply in the cycle right after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_rst | input | ADDR_W | Base value loaded during reset |
| reg_wr_en | input | 1 | Base register write strobe |
| reg_wr_priv | input | 1 | Write is privileged |
| reg_wr_data | input | ADDR_W | Write data |
| base_q | output | ADDR_W | Current table base |
| exc_req | input | 1 | Exception fetch request |
| exc_num | input | EXC_W | Exception number |
| exc_ready | output | 1 | Unit idle and able to accept a request |
| mem_req | output | 1 | Read strobe, one cycle |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | ADDR_W | Read data |
| boot_sp | output | ADDR_W | Initial stack pointer read at boot |
| boot_pc | output | ADDR_W | Reset handler address read at boot |
| boot_done | output | 1 | Boot reads finished |
| vec_valid | output | 1 | Handler result pulse |
| vec_handler | output | ADDR_W | Handler address read from the table |
| vec_err | output | 1 | Handler word has bit 0 clear |

## Verification
The boot sequence is run from two reset values. One is zero. The other has set bits below the alignment boundary, which shows whether those bits are cleared or passed into the read address. Exception reads are run with an interrupt number above 16 and with a low system number. Reply latencies of zero, two and five cycles show whether the result is taken from the reply strobe or from a fixed delay. One table word has bit 0 cleared, to separate the error path from a normal handler.

Privileged, unprivileged and all-ones writes test the mask and alignment bits. A request raised during a read in progress shows whether the unit ignores it or issues a second read.

// File: rtl/vfu_pkg.sv
package vfu_pkg;

  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_SP   = 3'd1,
    ST_PC   = 3'd2,
    ST_IDLE = 3'd3,
    ST_EXC  = 3'd4
  } fetch_st_e;

  // Byte-address bit count cleared by table alignment.
  function automatic int align_lsb(input int num_irq);
    int words;
    words = 16 + num_irq;
    if (words <= 32) return 7;
    return $clog2(words) + 2;
  endfunction

endpackage

// File: rtl/vfu_rst_sync.sv
module vfu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vfu_base_reg.sv
module vfu_base_reg #(
  parameter int              ADDR_W    = 32,
  parameter int              ALIGN_LSB = 8,
  parameter logic [ADDR_W-1:0] WR_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rst_val,
  input  logic              wr_en,
  input  logic              wr_priv,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q
);
  localparam logic [ADDR_W-1:0] ALIGN_KEEP = {ADDR_W{1'b1}} << ALIGN_LSB;
  localparam logic [ADDR_W-1:0] WR_KEEP    = WR_MASK & ALIGN_KEEP;

  logic              wr_ok;
  logic [ADDR_W-1:0] base_d;

  assign wr_ok = wr_en & wr_priv;

  always_comb begin
    base_d = base_q;
    if (wr_ok) base_d = (base_q & ~WR_KEEP) | (wr_data & WR_KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= rst_val & ALIGN_KEEP;
    else if (wr_ok) base_q <= base_d;
  end
endmodule

// File: rtl/vfu_addr_gen.sv
module vfu_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int EXC_W  = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [EXC_W-1:0]  word_idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - EXC_W - 2;

  logic [ADDR_W-1:0] byte_off;

  assign byte_off = {{PAD_W{1'b0}}, word_idx, 2'b00};
  assign addr     = base + byte_off;
endmodule

// File: rtl/vfu_fetch_ctrl.sv
module vfu_fetch_ctrl
  import vfu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int EXC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [EXC_W-1:0]  exc_num,
  output logic              exc_ready,
  output logic              mem_req,
  output logic [EXC_W-1:0]  word_idx,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] boot_sp,
  output logic [ADDR_W-1:0] boot_pc,
  output logic              boot_done,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_handler,
  output logic              vec_err
);
  fetch_st_e         st_q, st_d;
  logic              pend_q, pend_d;
  logic [EXC_W-1:0]  num_q, num_d;
  logic [ADDR_W-1:0] sp_d, pc_d, hd_d;
  logic              done_d, vv_d, err_d;
  logic              reply;

  assign reply     = pend_q & mem_rvalid;
  assign mem_req   = (st_q == ST_SP || st_q == ST_PC || st_q == ST_EXC) && !pend_q;
  assign exc_ready = (st_q == ST_IDLE);

  always_comb begin
    case (st_q)
      ST_SP:   word_idx = '0;
      ST_PC:   word_idx = EXC_W'(1);
      default: word_idx = num_q;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q | mem_req;
    num_d  = num_q;
    sp_d   = boot_sp;
    pc_d   = boot_pc;
    hd_d   = vec_handler;
    done_d = boot_done;
    vv_d   = 1'b0;
    err_d  = 1'b0;
    case (st_q)
      ST_INIT: st_d = ST_SP;
      ST_SP: if (reply) begin
        sp_d   = mem_rdata;
        pend_d = 1'b0;
        st_d   = ST_PC;
      end
      ST_PC: if (reply) begin
        pc_d   = mem_rdata;
        hd_d   = mem_rdata;
        vv_d   = 1'b1;
        err_d  = ~mem_rdata[0];
        done_d = 1'b1;
        pend_d = 1'b0;
        st_d   = ST_IDLE;
      end
      ST_IDLE: if (exc_req) begin
        num_d = exc_num;
        st_d  = ST_EXC;
      end
      ST_EXC: if (reply) begin
        hd_d   = mem_rdata;
        vv_d   = 1'b1;
        err_d  = ~mem_rdata[0];
        pend_d = 1'b0;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_INIT;
      pend_q      <= 1'b0;
      num_q       <= '0;
      boot_sp     <= '0;
      boot_pc     <= '0;
      vec_handler <= '0;
      boot_done   <= 1'b0;
      vec_valid   <= 1'b0;
      vec_err     <= 1'b0;
    end else begin
      st_q        <= st_d;
      pend_q      <= pend_d;
      num_q       <= num_d;
      boot_sp     <= sp_d;
      boot_pc     <= pc_d;
      vec_handler <= hd_d;
      boot_done   <= done_d;
      vec_valid   <= vv_d;
      vec_err     <= err_d;
    end
  end
endmodule

// File: rtl/vec_fetch_unit.sv
module vec_fetch_unit #(
  parameter int                ADDR_W  = 32,
  parameter int                NUM_IRQ = 21,
  parameter int                EXC_W   = 6,
  parameter logic [ADDR_W-1:0] WR_MASK = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base_rst,
  input  logic              reg_wr_en,
  input  logic              reg_wr_priv,
  input  logic [ADDR_W-1:0] reg_wr_data,
  output logic [ADDR_W-1:0] base_q,
  input  logic              exc_req,
  input  logic [EXC_W-1:0]  exc_num,
  output logic              exc_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] boot_sp,
  output logic [ADDR_W-1:0] boot_pc,
  output logic              boot_done,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_handler,
  output logic              vec_err
);
  localparam int ALIGN_LSB = vfu_pkg::align_lsb(NUM_IRQ);

  logic             rst_sync_n;
  logic [EXC_W-1:0] word_idx;

  vfu_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  vfu_base_reg #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB), .WR_MASK(WR_MASK)) u_base (
    .clk(clk), .rst_n(rst_sync_n), .rst_val(cfg_base_rst),
    .wr_en(reg_wr_en), .wr_priv(reg_wr_priv), .wr_data(reg_wr_data),
    .base_q(base_q)
  );

  vfu_addr_gen #(.ADDR_W(ADDR_W), .EXC_W(EXC_W)) u_addr (
    .base(base_q), .word_idx(word_idx), .addr(mem_addr)
  );

  vfu_fetch_ctrl #(.ADDR_W(ADDR_W), .EXC_W(EXC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .exc_req(exc_req), .exc_num(exc_num), .exc_ready(exc_ready),
    .mem_req(mem_req), .word_idx(word_idx),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .boot_sp(boot_sp), .boot_pc(boot_pc), .boot_done(boot_done),
    .vec_valid(vec_valid), .vec_handler(vec_handler), .vec_err(vec_err)
  );
endmodule

// File: rtl/vec_fetch_unit_chk.sv
module vec_fetch_unit_chk #(
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_wr_priv,
  input logic [ADDR_W-1:0] base_q,
  input logic              exc_ready,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic              boot_done,
  input logic              vec_valid,
  input logic [ADDR_W-1:0] vec_handler,
  input logic              vec_err
);
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outst_q <= 1'b0;
    else if (mem_req)    outst_q <= 1'b1;
    else if (mem_rvalid) outst_q <= 1'b0;
  end

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[ALIGN_LSB-1:0] == '0);                                          // R1
  AST_UNPRIV_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wr_priv) |=> $stable(base_q));                     // R3
  AST_DONE_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_done) |-> $past(mem_rvalid));                              // R4
  AST_VALID_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(mem_rvalid));                                     // R5
  AST_ERR_MATCHES_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |-> (vec_valid && !vec_handler[0]));                          // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !outst_q);                                                // R7
  AST_READY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ready |-> !mem_req);                                              // R7
endmodule

bind vec_fetch_unit vec_fetch_unit_chk #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_priv(reg_wr_priv),
  .base_q(base_q), .exc_ready(exc_ready), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .boot_done(boot_done), .vec_valid(vec_valid), .vec_handler(vec_handler), .vec_err(vec_err)
);

// File: tb/vec_fetch_unit_bench.sv
`timescale 1ns/1ps
module vec_fetch_unit_bench;
  localparam int AW = 32;
  localparam int EW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base_rst = '0;
  logic          reg_wr_en = 1'b0, reg_wr_priv = 1'b0;
  logic [AW-1:0] reg_wr_data = '0;
  logic [AW-1:0] base_q;
  logic          exc_req = 1'b0;
  logic [EW-1:0] exc_num = '0;
  logic          exc_ready, mem_req, mem_rvalid, boot_done, vec_valid, vec_err;
  logic [AW-1:0] mem_addr, mem_rdata, boot_sp, boot_pc, vec_handler;

  int total = 0, bad = 0;
  int lat = 0;
  int req_cnt = 0;
  logic [AW-1:0] req_log [0:7];
  logic [AW-1:0] bad_addr = 32'hFFFF_FFFF;
  logic          m_busy = 1'b0;
  int            m_cnt = 0;
  logic [AW-1:0] m_cap = '0;

  always #2.5 clk = ~clk;

  vec_fetch_unit u_vec_fetch_unit (
    .clk(clk), .rst_n(rst_n), .cfg_base_rst(cfg_base_rst),
    .reg_wr_en(reg_wr_en), .reg_wr_priv(reg_wr_priv), .reg_wr_data(reg_wr_data),
    .base_q(base_q), .exc_req(exc_req), .exc_num(exc_num), .exc_ready(exc_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .boot_sp(boot_sp), .boot_pc(boot_pc), .boot_done(boot_done),
    .vec_valid(vec_valid), .vec_handler(vec_handler), .vec_err(vec_err)
  );

  function automatic logic [AW-1:0] mem_word(input logic [AW-1:0] a);
    return (a << 4) | ((a == bad_addr) ? 32'h0 : 32'h1);
  endfunction

  // Memory model: takes a request at the negedge, answers after lat cycles.
  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (!rst_n) begin
      m_busy <= 1'b0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_word(m_cap);
        m_busy     <= 1'b0;
      end else m_cnt <= m_cnt - 1;
    end else if (mem_req) begin
      m_cap  <= mem_addr;
      m_cnt  <= lat;
      m_busy <= 1'b1;
      if (req_cnt < 8) req_log[req_cnt] <= mem_addr;
      req_cnt <= req_cnt + 1;
    end
  end

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
  end

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_boot(input logic [AW-1:0] cfg, input int l);
    logic [AW-1:0] eb;
    int early;
    eb = cfg & 32'hFFFF_FF00;
    lat = l;
    rst_n = 1'b0;
    cfg_base_rst = cfg;
    wait_cycles(3);
    req_cnt = 0;
    check("R1 base during reset", base_q, eb);
    check("R4 done low in reset", {31'd0, boot_done}, 32'd0);
    rst_n = 1'b1;
    early = 0;
    for (int i = 0; i < 200 && !boot_done; i++) begin
      @(negedge clk);
      if (boot_done && req_cnt < 2) early = 1;
      if (exc_ready && !boot_done) early = 1;
    end
    check("R4 done not early", early, 0);
    check("R4 boot done", {31'd0, boot_done}, 32'd1);
    check("R4 two reads", req_cnt, 2);
    check("R4 sp addr", req_log[0], eb);
    check("R4 pc addr", req_log[1], eb + 4);
    check("R4 boot sp", boot_sp, mem_word(eb));
    check("R4 boot pc", boot_pc, mem_word(eb + 4));
    check("R1 base after release", base_q, eb);
  endtask

  task automatic t_write(input logic priv, input logic [AW-1:0] d, input logic [AW-1:0] exp, input string req);
    reg_wr_en = 1'b1; reg_wr_priv = priv; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_priv = 1'b0;
    check(req, base_q, exp);
  endtask

  task automatic t_exc(input int num, input int l, input logic expect_err, input string req);
    logic [AW-1:0] ea;
    int c0, pulses, errs;
    ea = base_q + 32'(num) * 4;
    lat = l;
    c0 = req_cnt;
    pulses = 0; errs = 0;
    check({req, " ready"}, {31'd0, exc_ready}, 32'd1);
    exc_req = 1'b1; exc_num = EW'(num);
    @(negedge clk);
    exc_req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (vec_valid) begin
        pulses++;
        check({req, " handler"}, vec_handler, mem_word(ea));
        if (vec_err) errs++;
      end
      @(negedge clk);
    end
    check({req, " one read"}, req_cnt - c0, 1);
    check({req, " addr"}, req_log[c0], ea);
    check({req, " one pulse"}, pulses, 1);
    check("R6 error flag", errs, expect_err ? 1 : 0);
  endtask

  task automatic t_busy_ignore;
    int c0, pulses;
    logic [AW-1:0] ea;
    lat = 5;
    c0 = req_cnt;
    pulses = 0;
    ea = base_q + 20 * 4;
    exc_req = 1'b1; exc_num = 6'd20;
    @(negedge clk);
    exc_num = 6'd30;
    @(negedge clk);
    check("R7 ready low while busy", {31'd0, exc_ready}, 32'd0);
    @(negedge clk);
    exc_req = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (vec_valid) pulses++;
      @(negedge clk);
    end
    check("R7 single read", req_cnt - c0, 1);
    check("R7 addr of accepted num", req_log[c0], ea);
    check("R7 single result", pulses, 1);
    check("R7 handler", vec_handler, mem_word(ea));
  endtask

  initial begin
    t_boot(32'h0000_0000, 0);
    t_boot(32'h0000_1234, 2);
    t_write(1'b1, 32'hFFFF_FFFF, 32'h0FFF_FF00, "R2 all ones masked");
    t_write(1'b1, 32'h0000_4321, 32'h0000_4300, "R2 priv write");
    t_write(1'b0, 32'hAAAA_AA00, 32'h0000_4300, "R3 unpriv ignored");
    t_exc(36, 5, 1'b0, "R5 irq20");
    t_exc(11, 0, 1'b0, "R8 zero latency");
    bad_addr = 32'h0000_432C;
    t_exc(11, 2, 1'b1, "R6 bad vector");
    bad_addr = 32'hFFFF_FFFF;
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule